// File: doc/BRIEF.md
# Receive FIFO Error-Frame Admission Filter

This block is the write side of an Ethernet receive FIFO together with the logic that decides whether each incoming frame is kept or thrown away. Bytes arrive one per cycle with start and end markers. On the last byte, per-frame error flags arrive. The block holds each frame's bytes in a small entry buffer and keeps a saved start-of-frame pointer. When it decides to discard a frame, it rewinds the write pointer to that saved pointer, so the reader never sees any byte of the frame.

Two configuration bits steer the choice, and both are latched at the start of each frame. The forward-errors bit chooses between two policies: drop every error frame, or pass error frames on except runts. The store-and-forward bit chooses when a frame becomes visible. In store-and-forward mode a frame is visible only once it is complete and accepted. In threshold mode a frame is handed to the reader once `THRESH` of its bytes are stored. After that point the frame can no longer be dropped, so it is delivered, partial if it overflowed, with its error status.

Every delivered frame ends with one status entry that carries its error flags. Downstream logic can therefore see errors on frames that were forwarded.

Top module: `rxf_drop_filter`

## Requirements
- R1: After reset the buffer is empty and `out_valid` is 0.
- R2: With forward-errors clear, a frame not yet handed over is dropped if any `in_err` bit is set or it overflowed. The `in_err` bits are [0] CRC, [1] collision, [2] receive error, [3] giant, [4] watchdog timeout and [5] runt.
- R3: With forward-errors set, a frame not yet handed over is dropped only when its runt flag `in_err[5]` is set. Frames with other errors are delivered.
- R4: In store-and-forward mode, a frame that overflowed is always dropped, whatever forward-errors says.
- R5: In threshold mode, once `THRESH` bytes of a frame are stored, its stored bytes become readable before its end. From then on the frame is never dropped, whatever its flags.
- R6: In threshold mode, a frame that overflows after handover is delivered as its stored bytes followed by a status entry with the overflow bit set.
- R7: In store-and-forward mode, no entry of a frame is readable before the cycle after its end beat.
- R8: A delivered frame is read as its stored bytes in arrival order (`out_is_status`=0), then exactly one status entry (`out_is_status`=1). The status byte has `in_err[5:0]` in bits [5:0], overflow in bit 6 and 0 in bit 7.
- R9: A byte is stored only while occupancy is below `DEPTH-1`, which reserves a slot for the status entry. After the first refused byte, the rest of the frame is refused and the frame counts as overflowed. A frame that stored no byte is dropped.
- R10: A dropped frame leaves no entry on the read side. Frames before and after it are delivered unchanged.
- R11: The forward-errors and store-and-forward bits are sampled on the start beat. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fwd_err | input | 1 | 1: forward error frames except runts |
| cfg_store_fwd | input | 1 | 1: store-and-forward, 0: threshold mode |
| in_valid | input | 1 | Write beat present |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_err | input | 6 | Error flags, valid on the end beat |
| out_pop | input | 1 | Reader takes the current entry |
| out_valid | output | 1 | A committed entry is readable |
| out_data | output | 8 | Entry byte (data or status) |
| out_is_status | output | 1 | Entry is the status entry ending a frame |

## Verification
On every cycle, the assertions check four things:
- a drop leaves the write and commit pointers equal;
- between frames nothing is left uncommitted;
- occupancy never exceeds the depth;
- store-and-forward frames never advance the commit pointer before their end beat, and a handed-over frame stays fully committed.

Other behaviours can only be shown by the bench's scenarios. These are the choice between drop and forward for each mode, length and error flag, the exact contents of each delivered frame and its status byte, the early visibility of threshold frames, and the mid-frame mode changes being ignored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int ERR_W   = 6;
   localparam int E_CRC   = 0;
   localparam int E_COLL  = 1;
   localparam int E_RXER  = 2;
   localparam int E_GIANT = 3;
   localparam int E_WDOG  = 4;
   localparam int E_RUNT  = 5;
   localparam int S_OVF   = 6;

   typedef struct packed {
      logic       is_stat;
      logic [7:0] byte_v;
   } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
   import rxf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we0,
   input  logic [AW-1:0] wa0,
   input  rxf_entry_t    wd0,
   input  logic          we1,
   input  logic [AW-1:0] wa1,
   input  rxf_entry_t    wd1,
   input  logic [AW-1:0] ra,
   output rxf_entry_t    rd
);
   rxf_entry_t mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (we1 && wa1 == AW'(g))
            mem[g] <= wd1;
         else if (we0 && wa0 == AW'(g))
            mem[g] <= wd0;
      end
   end

   assign rd = mem[ra];

   always_ff @(posedge clk) begin
      if (we0 && we1) begin
         assert_dual_write_distinct_R8: assert (wa0 != wa1)
            else $error("two writes to one entry in one cycle");
      end
   end
endmodule

// File: rtl/rxf_admit_decide.sv
module rxf_admit_decide
   import rxf_pkg::*;
(
   input  logic             fwd_i,
   input  logic             sf_i,
   input  logic             handed_i,
   input  logic             ovf_i,
   input  logic             no_data_i,
   input  logic [ERR_W-1:0] err_i,
   output logic             drop_o,
   output logic [7:0]       status_o
);
   logic policy_drop;

   always_comb begin
      if (fwd_i)
         policy_drop = err_i[E_RUNT];
      else
         policy_drop = (|err_i) | ovf_i;
      drop_o = !handed_i && (no_data_i || (sf_i && ovf_i) || policy_drop);
      status_o = '0;
      status_o[ERR_W-1:0] = err_i;
      status_o[S_OVF] = ovf_i;
   end
endmodule

// File: rtl/rxf_drop_filter.sv
module rxf_drop_filter
   import rxf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int THRESH = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_fwd_err,
   input  logic             cfg_store_fwd,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [7:0]       in_data,
   input  logic [ERR_W-1:0] in_err,
   input  logic             out_pop,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_is_status
);
   initial begin
      assert_depth_pow2: assert (DEPTH >= 4 && (1 << AW) == DEPTH)
         else $error("DEPTH must be a power of two of at least 4");
      assert_thresh_range: assert (THRESH >= 1 && THRESH < DEPTH - 1)
         else $error("THRESH must lie in 1..DEPTH-2");
   end

   logic [PW-1:0] wr_ptr, commit_ptr, rd_ptr, sof_q, cnt_q;
   logic          in_frame, sf_q, fwd_q, ovf_q, hand_q;

   logic          accept_beat, cur_sf, cur_fwd, cur_ovf, cur_hand;
   logic [PW-1:0] cur_cnt, cur_sofp, occ, wp1, cnt1;
   logic          room, store_b, ovf1, hand1, end_b, drop, keep_end;
   logic [7:0]    status_b;
   rxf_entry_t    rd_ent;

   always_comb begin
      accept_beat = in_valid && (in_sof || in_frame);
      cur_sf   = in_sof ? cfg_store_fwd : sf_q;
      cur_fwd  = in_sof ? cfg_fwd_err   : fwd_q;
      cur_ovf  = in_sof ? 1'b0 : ovf_q;
      cur_hand = in_sof ? 1'b0 : hand_q;
      cur_cnt  = in_sof ? '0   : cnt_q;
      cur_sofp = in_sof ? wr_ptr : sof_q;
      occ      = wr_ptr - rd_ptr;
      room     = occ < PW'(DEPTH - 1);
      store_b  = accept_beat && room && !cur_ovf;
      wp1      = wr_ptr + PW'(store_b);
      cnt1     = cur_cnt + PW'(store_b);
      ovf1     = cur_ovf || (accept_beat && !store_b);
      hand1    = cur_hand || (!cur_sf && cnt1 >= PW'(THRESH));
      end_b    = accept_beat && in_eof;
      keep_end = end_b && !drop;
   end

   rxf_admit_decide u_decide (
      .fwd_i     (cur_fwd),
      .sf_i      (cur_sf),
      .handed_i  (hand1),
      .ovf_i     (ovf1),
      .no_data_i (cnt1 == '0),
      .err_i     (in_err),
      .drop_o    (drop),
      .status_o  (status_b)
   );

   rxf_store #(.DEPTH(DEPTH)) u_store (
      .clk (clk),
      .we0 (store_b),
      .wa0 (wr_ptr[AW-1:0]),
      .wd0 ('{is_stat: 1'b0, byte_v: in_data}),
      .we1 (keep_end),
      .wa1 (wp1[AW-1:0]),
      .wd1 ('{is_stat: 1'b1, byte_v: status_b}),
      .ra  (rd_ptr[AW-1:0]),
      .rd  (rd_ent)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         commit_ptr <= '0;
         rd_ptr     <= '0;
         sof_q      <= '0;
         cnt_q      <= '0;
         in_frame   <= 1'b0;
         sf_q       <= 1'b0;
         fwd_q      <= 1'b0;
         ovf_q      <= 1'b0;
         hand_q     <= 1'b0;
      end else begin
         if (accept_beat) begin
            sf_q     <= cur_sf;
            fwd_q    <= cur_fwd;
            sof_q    <= cur_sofp;
            cnt_q    <= cnt1;
            ovf_q    <= ovf1;
            hand_q   <= hand1;
            in_frame <= !in_eof;
            if (end_b && drop)
               wr_ptr <= cur_sofp;
            else if (keep_end)
               wr_ptr <= wp1 + PW'(1);
            else
               wr_ptr <= wp1;
            if (keep_end)
               commit_ptr <= wp1 + PW'(1);
            else if (hand1)
               commit_ptr <= wp1;
         end
         if (out_pop && out_valid)
            rd_ptr <= rd_ptr + PW'(1);
      end
   end

   assign out_valid     = rd_ptr != commit_ptr;
   assign out_data      = rd_ent.byte_v;
   assign out_is_status = rd_ent.is_stat;

   assert_drop_rewinds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (end_b && drop) |=> (wr_ptr == commit_ptr));

   assert_idle_committed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |-> (wr_ptr == commit_ptr));

   assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) <= PW'(DEPTH));

   assert_sf_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_beat && cur_sf && !in_eof) |=> $stable(commit_ptr));

   assert_handed_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && hand_q) |-> (commit_ptr == wr_ptr));
endmodule

// File: tb/tb_rxf_drop_filter.sv
module tb_rxf_drop_filter;
   localparam int DEPTH  = 16;
   localparam int THRESH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_fwd_err = 1'b0, cfg_store_fwd = 1'b0;
   logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0] in_data = '0;
   logic [5:0] in_err = '0;
   logic       out_pop = 1'b0;
   logic       out_valid, out_is_status;
   logic [7:0] out_data;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   logic [8:0] exp_q [64];
   int exp_n;
   logic probe_v;

   always #4 clk = ~clk;

   rxf_drop_filter #(.DEPTH(DEPTH), .THRESH(THRESH)) dut (.*);

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // Drives one frame starting at a negedge; probe_at samples out_valid after that beat.
   task automatic send_frame(input int len, input logic [5:0] flags, input int seed,
                             input int probe_at, input int chg_at);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == len - 1);
         in_data  = 8'((seed + i) & 255);
         in_err   = (i == len - 1) ? flags : 6'b0;
         if (i == chg_at) begin
            cfg_store_fwd = ~cfg_store_fwd;
            cfg_fwd_err   = ~cfg_fwd_err;
         end
         @(negedge clk);
         if (i == probe_at) probe_v = out_valid;
      end
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = '0;
   endtask

   function automatic void add_frame(input int len, input logic [5:0] flags, input int seed,
                                     input bit sf, input bit fwd, input int occ0);
      int stored; bit ovf, handed, drop;
      stored = (len < DEPTH - 1 - occ0) ? len : DEPTH - 1 - occ0;
      ovf    = len > stored;
      handed = !sf && stored >= THRESH;
      drop   = !handed && (stored == 0 || (sf && ovf) ||
                           (fwd ? flags[5] : ((|flags) || ovf)));
      if (!drop) begin
         for (int i = 0; i < stored; i++) exp_q[exp_n++] = {1'b0, 8'((seed + i) & 255)};
         exp_q[exp_n++] = {1'b1, 1'b0, ovf, flags};
      end
   endfunction

   task automatic drain_compare(input string tag);
      int n = 0; bit ok = 1'b1; int bad_a = 0, bad_e = 0;
      @(negedge clk);
      while (out_valid && n < 64) begin
         if (n >= exp_n || {out_is_status, out_data} != exp_q[n]) begin
            if (ok) begin
               bad_a = {out_is_status, out_data};
               bad_e = (n < exp_n) ? int'(exp_q[n]) : -1;
            end
            ok = 1'b0;
         end
         n++;
         out_pop = 1'b1;
         @(negedge clk);
         out_pop = 1'b0;
      end
      check(ok, tag, "entry contents (R8)", bad_a, bad_e);
      check(n == exp_n, tag, "entry count (R8)", n, exp_n);
      exp_n = 0;
   endtask

   initial begin
      int lens [7] = '{1, 3, 4, 5, 15, 16, 20};
      int seed = 1;
      string tag;
      exp_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // Sweep: mode x policy x length x single error flag
      for (int sf = 0; sf < 2; sf++)
         for (int fw = 0; fw < 2; fw++)
            for (int li = 0; li < 7; li++)
               for (int p = 0; p < 7; p++) begin
                  logic [5:0] fl = (p == 0) ? 6'b0 : 6'(1 << (p - 1));
                  bit ovf = lens[li] > DEPTH - 1;
                  bit hand = (sf == 0) && lens[li] >= THRESH;
                  cfg_store_fwd = sf[0]; cfg_fwd_err = fw[0];
                  if (sf == 1 && ovf) tag = "R4";
                  else if (hand && ovf) tag = "R6";
                  else if (hand) tag = "R5";
                  else if (fw == 1) tag = "R3";
                  else tag = "R2";
                  add_frame(lens[li], fl, seed, sf[0], fw[0], 0);
                  send_frame(lens[li], fl, seed, -1, -1);
                  drain_compare(tag);
                  seed += 37;
               end

      // R5 / R7: visibility of a partial frame before its end
      cfg_fwd_err = 1'b0;
      for (int sf = 0; sf < 2; sf++) begin
         cfg_store_fwd = sf[0];
         add_frame(8, 6'b0, seed, sf[0], 1'b0, 0);
         send_frame(8, 6'b0, seed, THRESH - 2, -1);
         check(probe_v == 1'b0, sf ? "R7" : "R5", "early visibility below threshold",
               probe_v, 0);
         drain_compare(sf ? "R7" : "R5");
         add_frame(8, 6'b0, seed, sf[0], 1'b0, 0);
         send_frame(8, 6'b0, seed, THRESH - 1, -1);
         check(probe_v == (sf == 0), sf ? "R7" : "R5", "visibility at threshold",
               probe_v, (sf == 0));
         drain_compare(sf ? "R7" : "R5");
         seed += 11;
      end

      // R9 / R10: back-to-back frames fill the buffer; third overflows and is dropped
      cfg_store_fwd = 1'b1; cfg_fwd_err = 1'b0;
      add_frame(6, 6'b0, 100, 1'b1, 1'b0, 0);
      add_frame(6, 6'b0, 120, 1'b1, 1'b0, 7);
      add_frame(6, 6'b0, 140, 1'b1, 1'b0, 14);
      send_frame(6, 6'b0, 100, -1, -1);
      send_frame(6, 6'b0, 120, -1, -1);
      send_frame(6, 6'b0, 140, -1, -1);
      drain_compare("R9");
      // R10: a dropped frame between good ones leaves them intact
      add_frame(3, 6'b0, 160, 1'b1, 1'b0, 0);
      send_frame(3, 6'b0, 160, -1, -1);
      send_frame(4, 6'b000001, 170, -1, -1);
      add_frame(2, 6'b0, 180, 1'b1, 1'b0, 4);
      send_frame(2, 6'b0, 180, -1, -1);
      drain_compare("R10");

      // R11: modes latched at the start beat; toggled after beat 1
      cfg_store_fwd = 1'b1; cfg_fwd_err = 1'b0;
      add_frame(8, 6'b000010, 200, 1'b1, 1'b0, 0);
      send_frame(8, 6'b000010, 200, 5, 1);
      check(probe_v == 1'b0, "R11", "sf frame visible after mid-frame mode change",
            probe_v, 0);
      drain_compare("R11");
      // now threshold + forward are the live settings; flip back mid-frame
      add_frame(3, 6'b000100, 210, 1'b0, 1'b1, 0);
      send_frame(3, 6'b000100, 210, -1, 1);
      drain_compare("R11");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule